// File: doc/BRIEF.md
# Mixed-Width Two-Port Synchronous RAM

This block is a synchronous memory with one write port and one read port, usable in the same cycle on independent addresses. The two ports see one shared array through different word widths: a narrow write port can fill a memory that is read back as wide words, or a wide write port can fill a memory that is read back narrow. Total capacity in bits is a parameter; each port's depth follows from it and from that port's width. The wider width must be the narrower one times a power of two.

Address, data and enables are taken on the rising edge of the input clock when the input clock enable is high. A read loads a read-data register in the input clock domain, and an asynchronous clear resets that register. An optional output register follows it, on its own clock, with its own clock enable and asynchronous clear. A parameter sets what a read returns when the write in the same cycle touches any of the bits it reads: the contents held before that write, or a value the user must not rely on.

Top module: `mw_sdp_ram`

## Requirements
- R1: With a narrow write port and a wide read port, a wide word at read address A is made of the narrow words at write addresses A*ratio up to A*ratio+ratio-1, with the lowest narrow address in bits [narrow-1:0] and each next one in the next higher slice.
- R2: A read and a write that touch different locations in the same input clock edge both take effect; the read returns the stored data.
- R3: In old-data mode, a read in the same edge as a write that overlaps it returns the contents before that write, and the write still lands.
- R4: In don't-care mode, a read that overlaps the write of the same edge returns a value with no meaning, the write still lands, and later reads of the location return the new data.
- R5: An edge with read enable low leaves the read data unchanged, even while the location last read is overwritten.
- R6: An edge with input clock enable low performs neither the write nor the read.
- R7: Asserting in_clr clears the read-data register to zero at once, without waiting for an edge, and leaves the array contents alone.
- R8: When the output register is present, rd_q takes the read-data register's value at the first out_clk edge with out_ce high, so a read taken at input edge N appears after output edge N+1 when both clocks are one; with out_ce low rd_q holds.
- R9: Asserting out_clr clears rd_q to zero at once.
- R10: With a wide write port and a narrow read port, narrow read address B returns slice B mod ratio of the wide word at write address B/ratio, slice 0 being the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for writes, address capture and the read-data register |
| in_ce | input | 1 | Clock enable for everything on in_clk |
| in_clr | input | 1 | Asynchronous clear of the read-data register, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | clog2(TOTAL_BITS/W_WIDTH) | Write address in write-port words |
| wr_data | input | W_WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | clog2(TOTAL_BITS/R_WIDTH) | Read address in read-port words |
| out_clk | input | 1 | Clock of the optional output register |
| out_ce | input | 1 | Clock enable of the output register |
| out_clr | input | 1 | Asynchronous clear of the output register, active high |
| rd_q | output | R_WIDTH | Read data |

## Verification
The hardest case to reach is a read whose address overlaps the write of the same edge when the two ports count addresses in different units. The overlap then depends on the write address shifted by the width ratio, not on equal address values. The stimulus fills known words first and then issues write and read in one cycle. In one collision the narrow write address lands in the middle of the wide word that is read, and in the other the narrow read address selects a middle slice of the wide word being written. The following reads show both what was returned and whether the write landed, and a reference array gives the expected value of every read that is not a collision.

// File: rtl/mw_sdp_pkg.sv
`timescale 1ns/1ps
package mw_sdp_pkg;

    // Result of a read overlapping the write of the same edge
    typedef enum logic {
        COLL_OLD_DATA  = 1'b0,
        COLL_DONT_CARE = 1'b1
    } coll_mode_e;

    function automatic int narrower(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mw_sdp_store.sv
`timescale 1ns/1ps
// Bit array kept at narrow-word granularity; each port touches
// a run of slices starting at its address times its slice count.
module mw_sdp_store #(
    parameter int MIN_W  = 4,
    parameter int NDEPTH = 256,
    parameter int WSL    = 1,
    parameter int RSL    = 4,
    parameter int WAW    = 8,
    parameter int RAW    = 6
) (
    input  logic                   clk,
    input  logic                   wr_go,
    input  logic [WAW-1:0]         wr_addr,
    input  logic [WSL*MIN_W-1:0]   wr_data,
    input  logic [RAW-1:0]         rd_addr,
    output logic [RSL*MIN_W-1:0]   rd_word
);
    localparam int NAW = $clog2(NDEPTH);

    logic [MIN_W-1:0] mem_q [NDEPTH];
    logic [MIN_W-1:0] mem_d [NDEPTH];
    logic [NAW-1:0]   wbase;
    logic [NAW-1:0]   rbase;

    assign wbase = NAW'(wr_addr) * NAW'(WSL);
    assign rbase = NAW'(rd_addr) * NAW'(RSL);

    always_comb begin
        mem_d = mem_q;
        if (wr_go) begin
            for (int k = 0; k < WSL; k++) begin
                mem_d[wbase + NAW'(k)] = wr_data[k*MIN_W +: MIN_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_comb begin
        for (int k = 0; k < RSL; k++) begin
            rd_word[k*MIN_W +: MIN_W] = mem_q[rbase + NAW'(k)];
        end
    end

endmodule

// File: rtl/mw_sdp_collide.sv
`timescale 1ns/1ps
// Flags a read whose narrow slices overlap the slices written in the same edge.
module mw_sdp_collide #(
    parameter int NAW = 8,
    parameter int WSL = 1,
    parameter int RSL = 4,
    parameter int WAW = 8,
    parameter int RAW = 6
) (
    input  logic           wr_go,
    input  logic           rd_go,
    input  logic [WAW-1:0] wr_addr,
    input  logic [RAW-1:0] rd_addr,
    output logic           hit
);
    localparam int SPAN  = (WSL > RSL) ? WSL : RSL;
    localparam int SHIFT = $clog2(SPAN);

    logic [NAW-1:0] wr_lo;
    logic [NAW-1:0] rd_lo;

    assign wr_lo = NAW'(wr_addr) * NAW'(WSL);
    assign rd_lo = NAW'(rd_addr) * NAW'(RSL);

    // Both runs are aligned to their own length, so overlap reduces
    // to equality above the longer run's alignment bits.
    assign hit = wr_go && rd_go && ((wr_lo >> SHIFT) == (rd_lo >> SHIFT));

endmodule

// File: rtl/mw_sdp_outreg.sv
`timescale 1ns/1ps
module mw_sdp_outreg #(
    parameter int W  = 16,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         ce,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            logic [W-1:0] q_d;
            logic [W-1:0] q_q;

            always_comb begin
                q_d = q_q;
                if (ce) q_d = d;
            end

            always_ff @(posedge clk or posedge clr) begin
                if (clr) q_q <= '0;
                else     q_q <= q_d;
            end

            assign q = q_q;

            p_out_hold_r8: assert property (@(posedge clk) disable iff (clr)
                !ce |=> $stable(q));
            p_out_load_r8: assert property (@(posedge clk) disable iff (clr)
                ce |=> (q == $past(d)));
            p_out_clr_r9: assert property (@(posedge clk)
                clr |-> (q == '0));
        end else begin : g_pass
            logic unused_in;
            assign unused_in = clk ^ ce ^ clr;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mw_sdp_ram.sv
`timescale 1ns/1ps
module mw_sdp_ram #(
    parameter int                     W_WIDTH    = 4,
    parameter int                     R_WIDTH    = 16,
    parameter int                     TOTAL_BITS = 1024,
    parameter bit                     OUT_REG    = 1'b1,
    parameter mw_sdp_pkg::coll_mode_e COLL_MODE  = mw_sdp_pkg::COLL_OLD_DATA
) (
    input  logic                                     in_clk,
    input  logic                                     in_ce,
    input  logic                                     in_clr,
    input  logic                                     wr_en,
    input  logic [$clog2(TOTAL_BITS/W_WIDTH)-1:0]    wr_addr,
    input  logic [W_WIDTH-1:0]                       wr_data,
    input  logic                                     rd_en,
    input  logic [$clog2(TOTAL_BITS/R_WIDTH)-1:0]    rd_addr,
    input  logic                                     out_clk,
    input  logic                                     out_ce,
    input  logic                                     out_clr,
    output logic [R_WIDTH-1:0]                       rd_q
);
    import mw_sdp_pkg::*;

    localparam int MIN_W  = narrower(W_WIDTH, R_WIDTH);
    localparam int NDEPTH = TOTAL_BITS / MIN_W;
    localparam int NAW    = $clog2(NDEPTH);
    localparam int WSL    = W_WIDTH / MIN_W;
    localparam int RSL    = R_WIDTH / MIN_W;
    localparam int WAW    = $clog2(TOTAL_BITS / W_WIDTH);
    localparam int RAW    = $clog2(TOTAL_BITS / R_WIDTH);

    typedef struct packed {
        logic [R_WIDTH-1:0] data;
    } rd_stage_t;

    logic               wr_go;
    logic               rd_go;
    logic               hit;
    logic [R_WIDTH-1:0] rd_word;
    rd_stage_t          rs_d;
    rd_stage_t          rs_q;

    assign wr_go = in_ce && wr_en;
    assign rd_go = in_ce && rd_en;

    mw_sdp_store #(
        .MIN_W (MIN_W),
        .NDEPTH(NDEPTH),
        .WSL   (WSL),
        .RSL   (RSL),
        .WAW   (WAW),
        .RAW   (RAW)
    ) i_store (
        .clk    (in_clk),
        .wr_go  (wr_go),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_word(rd_word)
    );

    mw_sdp_collide #(
        .NAW(NAW),
        .WSL(WSL),
        .RSL(RSL),
        .WAW(WAW),
        .RAW(RAW)
    ) i_collide (
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .hit    (hit)
    );

    always_comb begin
        rs_d = rs_q;
        if (rd_go) begin
            if (hit && (COLL_MODE == COLL_DONT_CARE)) rs_d.data = 'x;
            else                                      rs_d.data = rd_word;
        end
    end

    always_ff @(posedge in_clk or posedge in_clr) begin
        if (in_clr) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    mw_sdp_outreg #(
        .W (R_WIDTH),
        .EN(OUT_REG)
    ) i_outreg (
        .clk(out_clk),
        .ce (out_ce),
        .clr(out_clr),
        .d  (rs_q.data),
        .q  (rd_q)
    );

    p_rd_hold_r5: assert property (@(posedge in_clk) disable iff (in_clr)
        (in_ce && !rd_en) |=> $stable(rs_q.data));
    p_no_ce_r6: assert property (@(posedge in_clk) disable iff (in_clr)
        !in_ce |=> $stable(rs_q.data));
    p_rd_clr_r7: assert property (@(posedge in_clk)
        in_clr |-> (rs_q.data == '0));
    p_old_data_r3: assert property (@(posedge in_clk) disable iff (in_clr)
        (hit && (COLL_MODE == COLL_OLD_DATA)) |=> (rs_q.data == $past(rd_word)));

endmodule

// File: tb/test_mw_sdp_ram.sv
`timescale 1ns/1ps
module test_mw_sdp_ram;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic in_clr  = 1'b1;
    logic out_clr = 1'b1;
    logic out_ce  = 1'b1;

    // instance A: 4-bit write, 16-bit read, old-data, output register
    logic        a_ce = 0, a_we = 0, a_re = 0;
    logic [7:0]  a_wa = '0;
    logic [3:0]  a_wd = '0;
    logic [5:0]  a_ra = '0;
    logic [15:0] a_q;

    // instance B: 16-bit write, 4-bit read, don't-care, no output register
    logic        b_ce = 0, b_we = 0, b_re = 0;
    logic [5:0]  b_wa = '0;
    logic [15:0] b_wd = '0;
    logic [7:0]  b_ra = '0;
    logic [3:0]  b_q;

    mw_sdp_ram #(
        .W_WIDTH(4), .R_WIDTH(16), .TOTAL_BITS(1024), .OUT_REG(1'b1),
        .COLL_MODE(mw_sdp_pkg::COLL_OLD_DATA)
    ) i_mw_sdp_ram (
        .in_clk(clk), .in_ce(a_ce), .in_clr(in_clr),
        .wr_en(a_we), .wr_addr(a_wa), .wr_data(a_wd),
        .rd_en(a_re), .rd_addr(a_ra),
        .out_clk(clk), .out_ce(out_ce), .out_clr(out_clr),
        .rd_q(a_q)
    );

    mw_sdp_ram #(
        .W_WIDTH(16), .R_WIDTH(4), .TOTAL_BITS(1024), .OUT_REG(1'b0),
        .COLL_MODE(mw_sdp_pkg::COLL_DONT_CARE)
    ) i_mw_sdp_ram_dc (
        .in_clk(clk), .in_ce(b_ce), .in_clr(in_clr),
        .wr_en(b_we), .wr_addr(b_wa), .wr_data(b_wd),
        .rd_en(b_re), .rd_addr(b_ra),
        .out_clk(clk), .out_ce(1'b0), .out_clr(1'b0),
        .rd_q(b_q)
    );

    typedef struct {
        int          due;
        bit          inst_b;
        bit          care;
        logic [15:0] exp;
        int          req;
    } sb_t;

    sb_t         sb[$];
    logic [3:0]  ref_a [256];
    logic [3:0]  ref_b [256];
    int          cyc = 0;
    int          vectors = 0;
    int          miscompares = 0;
    bit          no_push = 0;
    logic [15:0] a_last = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] a_wide(input int w);
        return {ref_a[w*4+3], ref_a[w*4+2], ref_a[w*4+1], ref_a[w*4]};
    endfunction

    task automatic chk(input bit ok, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL R%0d: got %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: compares every due scoreboard item at the falling edge
    always @(negedge clk) begin
        int i;
        logic [15:0] act;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].due == cyc) begin
                act = sb[i].inst_b ? {12'h000, b_q} : a_q;
                if (sb[i].care) chk(act == sb[i].exp, sb[i].req, act, sb[i].exp);
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic idle(input int n);
        @(negedge clk);
        a_ce = 1; a_we = 0; a_re = 0;
        b_ce = 1; b_we = 0; b_re = 0;
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    task automatic a_cycle(input bit we, input logic [7:0] wa, input logic [3:0] wd,
                           input bit re, input logic [5:0] ra, input bit ce,
                           input int req);
        sb_t e;
        @(negedge clk);
        a_ce = ce; a_we = we; a_wa = wa; a_wd = wd; a_re = re; a_ra = ra;
        b_we = 0; b_re = 0;
        @(posedge clk);
        #1;
        if (ce) begin
            if (re) begin
                e.due = cyc + 1; e.inst_b = 0; e.care = 1;
                e.exp = a_wide(int'(ra)); e.req = req;
                if (!no_push) sb.push_back(e);
                a_last = e.exp;
            end
            if (we) ref_a[wa] = wd;
        end
    endtask

    task automatic b_cycle(input bit we, input logic [5:0] wa, input logic [15:0] wd,
                           input bit re, input logic [7:0] ra, input int req);
        sb_t e;
        @(negedge clk);
        b_ce = 1; b_we = we; b_wa = wa; b_wd = wd; b_re = re; b_ra = ra;
        a_we = 0; a_re = 0;
        @(posedge clk);
        #1;
        if (re) begin
            e.due = cyc; e.inst_b = 1;
            e.care = !(we && (wa == ra[7:2]));
            e.exp = {12'h000, ref_b[ra]}; e.req = req;
            sb.push_back(e);
        end
        if (we) for (int k = 0; k < 4; k++) ref_b[{wa, 2'(k)}] = wd[k*4 +: 4];
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(a_q == 16'h0, 7, a_q, 16'h0);            // R7, R9 reset state
        chk(b_q == 4'h0, 7, {12'h0, b_q}, 16'h0);    // R7
        in_clr = 0; out_clr = 0;

        // R1: fill narrow 0..63, read wide 0..15
        for (int i = 0; i < 64; i++) a_cycle(1, 8'(i), 4'((i*7+3) & 15), 0, 6'd0, 1, 1);
        for (int i = 0; i < 16; i++) a_cycle(0, 8'd0, 4'd0, 1, 6'(i), 1, 1);

        // R2: independent write and read in one edge
        a_cycle(1, 8'd100, 4'hA, 1, 6'd2, 1, 2);
        // R3: write narrow 5 (middle of wide 1) while reading wide 1
        a_cycle(1, 8'd5, 4'hC, 1, 6'd1, 1, 3);
        a_cycle(0, 8'd0, 4'd0, 1, 6'd1, 1, 3);      // R3 write landed
        idle(4);

        // R5: read enable low holds while location is overwritten
        a_cycle(0, 8'd0, 4'd0, 1, 6'd3, 1, 5);
        idle(3);
        keep = a_last;
        a_cycle(1, 8'd12, ~ref_a[12], 0, 6'd3, 1, 5);
        idle(3);
        @(negedge clk);
        chk(a_q == keep, 5, a_q, keep);              // R5
        a_cycle(0, 8'd0, 4'd0, 1, 6'd3, 1, 5);

        // R6: clock enable low, no write and no read
        idle(3);
        keep = a_last;
        a_cycle(1, 8'd13, ~ref_a[13], 1, 6'd0, 0, 6);
        idle(3);
        @(negedge clk);
        chk(a_q == keep, 6, a_q, keep);              // R6 no read
        a_cycle(0, 8'd0, 4'd0, 1, 6'd3, 1, 6);      // R6 no write
        idle(3);

        // R10: wide write, narrow read
        for (int i = 0; i < 8; i++) b_cycle(1, 6'(i), 16'(i*16'h1357 + 16'h2468), 0, 8'd0, 10);
        for (int i = 0; i < 32; i++) b_cycle(0, 6'd0, 16'h0, 1, 8'(i), 10);
        // R4: write wide 2 while reading narrow 9 (slice 1 of wide 2)
        b_cycle(1, 6'd2, 16'hBEEF, 1, 8'd9, 4);
        b_cycle(0, 6'd0, 16'h0, 1, 8'd9, 4);
        b_cycle(0, 6'd0, 16'h0, 1, 8'd10, 4);
        // R2: write wide 3 while reading narrow 1
        b_cycle(1, 6'd3, 16'h7E81, 1, 8'd1, 2);
        b_cycle(0, 6'd0, 16'h0, 1, 8'd13, 2);
        idle(3);

        // R7: asynchronous clear of the read-data register
        @(negedge clk);
        in_clr = 1;
        #1;
        chk(b_q == 4'h0, 7, {12'h0, b_q}, 16'h0);    // R7 immediate
        @(posedge clk);
        @(negedge clk);
        chk(a_q == 16'h0, 7, a_q, 16'h0);            // R7 through output reg
        in_clr = 0;
        a_last = 16'h0;
        a_cycle(0, 8'd0, 4'd0, 1, 6'd3, 1, 7);      // R7 array kept
        idle(3);
        @(negedge clk);
        in_clr = 1;
        @(posedge clk);
        @(negedge clk);
        in_clr = 0;
        idle(2);

        // R8: out_ce low holds rd_q, then one edge loads it
        @(negedge clk);
        out_ce = 0;
        no_push = 1;
        a_cycle(0, 8'd0, 4'd0, 1, 6'd5, 1, 8);
        no_push = 0;
        idle(3);
        @(negedge clk);
        chk(a_q == 16'h0, 8, a_q, 16'h0);            // R8 hold
        out_ce = 1;
        @(posedge clk);
        @(negedge clk);
        chk(a_q == a_wide(5), 8, a_q, a_wide(5));    // R8 load

        // R9: out_clr clears rd_q at once
        out_clr = 1;
        #1;
        chk(a_q == 16'h0, 9, a_q, 16'h0);            // R9
        @(posedge clk);
        @(negedge clk);
        out_clr = 0;
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule